// File: doc/BRIEF.md
# Burst column address sequencer

This block keeps a programmable mode word for a DDR-style memory and expands each burst command into the ordered column addresses of that burst, one address per data beat. The mode word sets the burst length (2, 4 or 8 beats), the burst order (sequential or interleaved), a CAS latency code and a six-bit operating-mode field. A burst wraps inside an aligned block of columns whose size equals the burst length. The column bits above that block stay at the value given with the start command.

A mode load is a mode-set strobe with both bank-select bits low. The block accepts it only while the banks report idle and no burst is running. A load that is rejected, or that carries a reserved length code, raises a one-cycle error flag and leaves the stored word as it was. A read start and a write start both begin a burst in the same way.

The controller is a two-state machine. **ST_IDLE** moves to **ST_RUN** on transition *start*, which is a read or write strobe seen in ST_IDLE. It captures the start column, the length and the order, and clears the beat counter. **ST_RUN** has two transitions. On *advance*, which is any beat but the last, it stays in ST_RUN and increments the counter. On *finish*, which is the last beat, it returns to ST_IDLE. Start strobes are not decoded in ST_RUN.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the beat-valid, burst-last and error outputs are 0 and the operating-mode output is 0. The CAS latency output reads 2. A burst then runs 2 beats in sequential order.
- R2: An accepted load takes mode_addr_i[2:0] as the length code (001 = 2, 010 = 4, 011 = 8) and mode_addr_i[3] as the order (0 sequential, 1 interleaved). It takes mode_addr_i[6:4] as the CAS latency code and mode_addr_i[12:7] as the operating-mode field. The new values show on the outputs in the cycle after the strobe edge.
- R3: A mode-set strobe with bank_sel_i other than 00 changes nothing and raises no error.
- R4: Operating-mode bit 1, which is address bit 8, reads 1 in the cycle after the load that set it. It reads 0 in the cycle after that unless a new load sets it again. The other operating-mode bits hold.
- R5: A load with a length code of 000 or 1xx raises mode_err_o for one cycle and keeps the whole prior mode.
- R6: A load while banks_idle_i is 0, or while a burst is running, is ignored and raises mode_err_o for one cycle.
- R7: After a start strobe, beat_vld_o is 1 for exactly burst-length cycles, starting in the cycle after the strobe edge. beat_last_o is 1 only on the final beat.
- R8: During a burst, column bits at and above the burst-length boundary equal those of the start column.
- R9: In sequential order the low column bits start at the start offset, rise by one each beat, and wrap inside the block.
- R10: In interleaved order the low column bits on beat i equal the start offset XOR i.
- R11: A start strobe while a burst is running is ignored. The running burst keeps its addresses and ends on time.
- R12: A write start produces the same column sequence as a read start with the same start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mrs_i | input | 1 | Mode-set strobe |
| bank_sel_i | input | 2 | Bank-select bits; 00 addresses the mode word |
| mode_addr_i | input | 13 | Mode word carried with the strobe |
| banks_idle_i | input | 1 | All banks idle |
| rd_go_i | input | 1 | Read burst start strobe |
| wr_go_i | input | 1 | Write burst start strobe |
| start_col_i | input | COL_W | Start column of the burst |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is active this cycle |
| beat_last_o | output | 1 | Current beat is the last of the burst |
| cas_lat_o | output | 3 | Stored CAS latency code |
| op_mode_o | output | 6 | Stored operating-mode field |
| mode_err_o | output | 1 | Rejected or illegal mode-set request, one cycle |

## Verification
Every result is one register away from its stimulus. A mode load, a rejection error or a self-clear shows in the cycle after the strobe's edge. The first beat of a burst appears in the cycle after the start strobe's edge, and each later beat one cycle after the one before it. Inputs change on the falling edge and outputs are sampled on the next falling edge. Each check therefore reads the value the closest rising edge produced: the beat index equals the number of falling edges since the start strobe was dropped. The bench checks the end of a burst exactly burst-length cycles after it starts, and checks the error flag both in its pulse cycle and in the cycle after.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int MODE_W   = 13;
    localparam int CL_LSB   = 4;
    localparam int CL_W     = 3;
    localparam int OP_LSB   = 7;
    localparam int OP_W     = 6;
    localparam int OP_PULSE = 1;   // operating-mode bit that clears itself
    localparam int ORD_BIT  = 3;
    localparam int LEN_W    = 2;   // log2 of burst length
    localparam int BEAT_W   = 3;   // log2 of the longest burst

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bcs_state_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [CL_W-1:0]  cl;
        logic             ilv;
        logic [LEN_W-1:0] len_log;
    } bcs_mode_t;

    function automatic logic len_code_ok(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mrs_i,
    input  logic [1:0]        bank_sel_i,
    input  logic [MODE_W-1:0] mode_addr_i,
    input  logic              banks_idle_i,
    input  logic              busy_i,
    output bcs_mode_t         mode_o,
    output logic              err_o
);
    bcs_mode_t mode_q;
    bcs_mode_t mode_new;
    logic      req, blocked, bad_len, accept;

    always_comb begin
        req      = mrs_i && (bank_sel_i == 2'b00);
        blocked  = busy_i || !banks_idle_i;
        bad_len  = !len_code_ok(mode_addr_i[2:0]);
        accept   = req && !blocked && !bad_len;
        mode_new.op      = mode_addr_i[OP_LSB +: OP_W];
        mode_new.cl      = mode_addr_i[CL_LSB +: CL_W];
        mode_new.ilv     = mode_addr_i[ORD_BIT];
        mode_new.len_log = mode_addr_i[LEN_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q.op      <= '0;
            mode_q.cl      <= 3'd2;
            mode_q.ilv     <= 1'b0;
            mode_q.len_log <= 2'd1;
            err_o          <= 1'b0;
        end else begin
            err_o <= req && (blocked || bad_len);
            if (accept) begin
                mode_q <= mode_new;
            end else begin
                mode_q.op[OP_PULSE] <= 1'b0;
            end
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/bcs_burst_fsm.sv
module bcs_burst_fsm
    import bcs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  logic [LEN_W-1:0]  len_log_i,
    output logic              start_o,
    output logic [BEAT_W-1:0] cnt_o,
    output logic              vld_o,
    output logic              last_o
);
    bcs_state_e        state_q, state_d;
    logic [BEAT_W-1:0] cnt_q;
    logic [LEN_W-1:0]  len_q;
    logic [BEAT_W-1:0] final_cnt;

    for (genvar gi = 0; gi < BEAT_W; gi++) begin : g_final
        assign final_cnt[gi] = (int'(len_q) > gi);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_i)               state_d = ST_RUN;
            ST_RUN:  if (cnt_q == final_cnt) state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= 2'd1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && go_i) begin
                cnt_q <= '0;
                len_q <= len_log_i;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        start_o = (state_q == ST_IDLE) && go_i;
        vld_o   = (state_q == ST_RUN);
        last_o  = vld_o && (cnt_q == final_cnt);
        cnt_o   = cnt_q;
    end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic              ilv_i,
    input  logic [LEN_W-1:0]  len_log_i,
    input  logic [BEAT_W-1:0] cnt_i,
    output logic [COL_W-1:0]  col_o
);
    logic [COL_W-1:0]  base_q;
    logic              ilv_q;
    logic [LEN_W-1:0]  len_q;
    logic [BEAT_W-1:0] mask, low, off_seq, off_ilv, off;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            base_q <= '0;
            ilv_q  <= 1'b0;
            len_q  <= 2'd1;
        end else if (load_i) begin
            base_q <= start_col_i;
            ilv_q  <= ilv_i;
            len_q  <= len_log_i;
        end
    end

    for (genvar gi = 0; gi < BEAT_W; gi++) begin : g_mask
        assign mask[gi] = (int'(len_q) > gi);
    end

    always_comb begin
        low     = base_q[BEAT_W-1:0];
        off_seq = low + cnt_i;
        off_ilv = low ^ cnt_i;
        off     = ilv_q ? off_ilv : off_seq;
        col_o   = {base_q[COL_W-1:BEAT_W], (off & mask) | (low & ~mask)};
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mrs_i,
    input  logic [1:0]        bank_sel_i,
    input  logic [MODE_W-1:0] mode_addr_i,
    input  logic              banks_idle_i,
    input  logic              rd_go_i,
    input  logic              wr_go_i,
    input  logic [COL_W-1:0]  start_col_i,
    output logic [COL_W-1:0]  col_o,
    output logic              beat_vld_o,
    output logic              beat_last_o,
    output logic [CL_W-1:0]   cas_lat_o,
    output logic [OP_W-1:0]   op_mode_o,
    output logic              mode_err_o
);
    bcs_mode_t         mode;
    logic              start, vld, last;
    logic [BEAT_W-1:0] cnt;

    bcs_mode_reg u_mode (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mrs_i        (mrs_i),
        .bank_sel_i   (bank_sel_i),
        .mode_addr_i  (mode_addr_i),
        .banks_idle_i (banks_idle_i),
        .busy_i       (vld),
        .mode_o       (mode),
        .err_o        (mode_err_o)
    );

    bcs_burst_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .go_i      (rd_go_i || wr_go_i),
        .len_log_i (mode.len_log),
        .start_o   (start),
        .cnt_o     (cnt),
        .vld_o     (vld),
        .last_o    (last)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_col (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (start),
        .start_col_i (start_col_i),
        .ilv_i       (mode.ilv),
        .len_log_i   (mode.len_log),
        .cnt_i       (cnt),
        .col_o       (col_o)
    );

    assign beat_vld_o  = vld;
    assign beat_last_o = last;
    assign cas_lat_o   = mode.cl;
    assign op_mode_o   = mode.op;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             mrs_i,
    input logic [1:0]       bank_sel_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             beat_last_o,
    input logic [CL_W-1:0]  cas_lat_o,
    input logic [OP_W-1:0]  op_mode_o,
    input logic             mode_err_o
);
    AST_LAST_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beat_last_o |-> beat_vld_o); // R7

    AST_LAST_ENDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beat_last_o |=> !beat_vld_o); // R11

    AST_BLOCK_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (beat_vld_o && !beat_last_o) |=> (col_o[COL_W-1:BEAT_W] == $past(col_o[COL_W-1:BEAT_W]))); // R8

    AST_NO_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beat_vld_o |=> ($stable(cas_lat_o) && $stable(op_mode_o[OP_W-1:OP_PULSE+1]))); // R6

    AST_ERR_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mode_err_o) |-> $past(mrs_i && (bank_sel_i == 2'b00))); // R3

    AST_PULSE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_mode_o[OP_PULSE] && !(mrs_i && (bank_sel_i == 2'b00))) |=> !op_mode_o[OP_PULSE]); // R4
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mrs_i       (mrs_i),
    .bank_sel_i  (bank_sel_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .beat_last_o (beat_last_o),
    .cas_lat_o   (cas_lat_o),
    .op_mode_o   (op_mode_o),
    .mode_err_o  (mode_err_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             mrs_i = 1'b0;
    logic [1:0]       bank_sel_i = 2'b00;
    logic [12:0]      mode_addr_i = '0;
    logic             banks_idle_i = 1'b1;
    logic             rd_go_i = 1'b0;
    logic             wr_go_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [COL_W-1:0] col_o;
    logic             beat_vld_o, beat_last_o, mode_err_o;
    logic [2:0]       cas_lat_o;
    logic [5:0]       op_mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side view of the stored mode
    int exp_lg = 1;
    bit exp_il = 0;
    int exp_cl = 2;

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
        .clk_i(clk), .rst_ni(rst_ni), .mrs_i(mrs_i), .bank_sel_i(bank_sel_i),
        .mode_addr_i(mode_addr_i), .banks_idle_i(banks_idle_i),
        .rd_go_i(rd_go_i), .wr_go_i(wr_go_i), .start_col_i(start_col_i),
        .col_o(col_o), .beat_vld_o(beat_vld_o), .beat_last_o(beat_last_o),
        .cas_lat_o(cas_lat_o), .op_mode_o(op_mode_o), .mode_err_o(mode_err_o));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int lg, input bit il, input int i);
        int n  = 1 << lg;
        int lo = s % n;
        int off = il ? (lo ^ i) : ((lo + i) % n);
        return (s - lo) + off;
    endfunction

    function automatic logic [12:0] word(input int op, input int cl, input bit il, input int bl);
        return {op[5:0], cl[2:0], il, bl[2:0]};
    endfunction

    task automatic do_mrs(input logic [1:0] bank, input logic [12:0] addr, input bit idle);
        @(negedge clk);
        mrs_i = 1'b1; bank_sel_i = bank; mode_addr_i = addr; banks_idle_i = idle;
        @(negedge clk);
        mrs_i = 1'b0; bank_sel_i = 2'b00; banks_idle_i = 1'b1;
    endtask

    // runs one burst, checking every beat against the model
    task automatic run_burst(input string req, input int s, input bit wr, input bit hold_go);
        int n = 1 << exp_lg;
        @(negedge clk);
        start_col_i = COL_W'(s);
        if (wr) wr_go_i = 1'b1; else rd_go_i = 1'b1;
        @(negedge clk);
        if (!hold_go) begin rd_go_i = 1'b0; wr_go_i = 1'b0; end
        else start_col_i = COL_W'(s ^ 10'h3A5);
        for (int i = 0; i < n; i++) begin
            check({req, " col"}, int'(col_o), exp_col(s, exp_lg, exp_il, i));
            check({req, " vld"}, int'(beat_vld_o), 1);
            check({req, " last"}, int'(beat_last_o), int'(i == n - 1));
            @(negedge clk);
        end
        rd_go_i = 1'b0; wr_go_i = 1'b0;
        check({req, " R7 end"}, int'(beat_vld_o), 0);
    endtask

    task automatic t_reset;
        check("R1 vld", int'(beat_vld_o), 0);
        check("R1 last", int'(beat_last_o), 0);
        check("R1 err", int'(mode_err_o), 0);
        check("R1 cas", int'(cas_lat_o), 2);
        check("R1 op", int'(op_mode_o), 0);
        run_burst("R1 default", 3, 0, 0);
    endtask

    task automatic t_load(input int op, input int cl, input bit il, input int bl);
        do_mrs(2'b00, word(op, cl, il, bl), 1'b1);
        exp_lg = bl; exp_il = il; exp_cl = cl;
        check("R2 cas", int'(cas_lat_o), cl);
        check("R2 op", int'(op_mode_o), op);
        check("R2 err", int'(mode_err_o), 0);
    endtask

    task automatic t_bank_sel;
        do_mrs(2'b01, word(0, 5, 1, 3), 1'b1);
        check("R3 cas", int'(cas_lat_o), exp_cl);
        check("R3 err", int'(mode_err_o), 0);
        run_burst("R3 order kept", 6, 0, 0);
    endtask

    task automatic t_pulse;
        do_mrs(2'b00, word(6'b000011, exp_cl, exp_il, exp_lg), 1'b1);
        check("R4 set", int'(op_mode_o), 6'b000011);
        @(negedge clk);
        check("R4 cleared", int'(op_mode_o), 6'b000001);
    endtask

    task automatic t_reserved(input int bl);
        do_mrs(2'b00, word(6'b100000, 7, ~exp_il, bl), 1'b1);
        check("R5 err", int'(mode_err_o), 1);
        check("R5 cas", int'(cas_lat_o), exp_cl);
        @(negedge clk);
        check("R5 err one cycle", int'(mode_err_o), 0);
        run_burst("R5 length kept", 1, 0, 0);
    endtask

    task automatic t_not_idle;
        do_mrs(2'b00, word(0, 6, 0, 1), 1'b0);
        check("R6 idle err", int'(mode_err_o), 1);
        check("R6 idle cas", int'(cas_lat_o), exp_cl);
        @(negedge clk);
        check("R6 idle err clears", int'(mode_err_o), 0);
    endtask

    task automatic t_busy;
        @(negedge clk);
        start_col_i = 10'h010; rd_go_i = 1'b1;
        @(negedge clk);
        rd_go_i = 1'b0;
        mrs_i = 1'b1; bank_sel_i = 2'b00; mode_addr_i = word(0, 6, 0, 1);
        @(negedge clk);
        mrs_i = 1'b0;
        check("R6 busy err", int'(mode_err_o), 1);
        check("R6 busy cas", int'(cas_lat_o), exp_cl);
        for (int k = 0; k < 12 && beat_vld_o; k++) @(negedge clk);
        check("R6 busy err clears", int'(mode_err_o), 0);
        check("R6 busy cas after", int'(cas_lat_o), exp_cl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_load(6'b000001, 3, 0, 2);
        run_burst("R9 seq len4", 1, 0, 0);
        run_burst("R8 R12 seq len4 wr", 10'h2D, 1, 0);
        t_load(0, 2, 1, 3);
        run_burst("R10 ilv len8", 10'h15, 0, 0);
        run_burst("R12 ilv len8 wr", 10'h15, 1, 0);
        t_bank_sel();
        t_load(0, 2, 0, 3);
        run_burst("R9 seq len8", 10'h3E6, 0, 0);
        run_burst("R11 go held", 10'h0C3, 0, 1);
        t_load(0, 3, 1, 2);
        run_burst("R10 ilv len4", 10'h102, 1, 0);
        t_load(0, 3, 1, 1);
        run_burst("R10 ilv len2", 10'h0F1, 0, 0);
        t_pulse();
        t_reserved(0);
        t_reserved(5);
        t_not_idle();
        t_load(0, 2, 0, 3);
        t_busy();
        run_burst("R6 mode kept", 10'h007, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule